// File: doc/BRIEF.md
# Serial Port Master Frame Generator

This block is the clock-owning side of a synchronous serial data link to a host signal processor. It divides the system clock by a fixed ratio to produce the serial bit clock and marks the start of each frame with a one-bit-period sync pulse. In each frame it shifts one parallel transmit word out to the host and assembles one word received from the host into a parallel result.

Bit periods are numbered by a slot index 0 to 255 within a frame. A slot begins on a rising edge of the bit clock. Slot 0 is the frame boundary. The data word occupies slots 1 to 16, and the remaining slots are idle. A frame-type input chooses whether the sync pulse comes one bit period ahead of the first data bit (early) or alongside it (late). Tying the input low, as a pull-down on an open pin does, selects early timing.

Top module: `sport_frame_master`

## Requirements
- R1: `sclk` is the system clock divided by 18. After reset it stays low until the 18th rising edge of `clk`. From then on it is high for 9 `clk` cycles and low for 9, repeating.
- R2: A frame is 256 bit periods, so 4608 `clk` cycles. The first rising edge of `sclk` after reset starts slot 0 of the first frame.
- R3: With `frame_late` = 0 (early), `fsync` is high for exactly the bit period of slot 0, which is the period before the first data bit. It changes only together with a rising edge of `sclk`.
- R4: With `frame_late` = 1 (late), `fsync` is high for exactly the bit period of slot 1, which holds the first data bit. The value of `frame_late` at each rising edge of `sclk` decides the timing.
- R5: `tx_word` is captured at the rising edge of `sclk` that starts slot 0, and `tx_load` is high for that one `clk` cycle. Changes to `tx_word` at any other time have no effect on the data sent in that frame.
- R6: `sdo` carries the captured word MSB first. Bit 15 is in slot 1 and bit 0 is in slot 16, and `sdo` changes only with a rising edge of `sclk`.
- R7: `sdo` is low during slot 0 and during slots 17 to 255.
- R8: `sdi` is sampled at the falling edge of `sclk` in slots 1 to 16. The bit sampled in slot 1 becomes bit 15 of the received word and the bit sampled in slot 16 becomes bit 0.
- R9: `rx_word` updates, and `rx_valid` is high for one `clk` cycle, in the cycle in which `sclk` goes low in slot 16. `rx_word` holds its value at all other times, and `sdi` during idle slots has no effect on it.
- R10: While `rst` is high, `sclk`, `fsync`, `sdo`, `tx_load` and `rx_valid` are low and `rx_word` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_late | input | 1 | 0 = early frame sync, 1 = late frame sync |
| tx_word | input | 16 | Word to send in the next frame |
| sdi | input | 1 | Serial data from the host |
| sclk | output | 1 | Serial bit clock, system clock / 18 |
| fsync | output | 1 | Frame sync pulse, one bit period long |
| sdo | output | 1 | Serial data to the host |
| tx_load | output | 1 | One-cycle strobe when `tx_word` is captured |
| rx_word | output | 16 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_word` updates |

## Verification
The hardest case to reach from the ports is showing that the word in flight is isolated from everything outside its own window. A late change of `tx_word` must not reach `sdo`, and host data in the idle slots must not reach `rx_word`. The stimulus randomizes `sdi` on every system clock and rewrites `tx_word` at arbitrary points inside frames. The result then depends on exactly which falling edges and which frame boundary the design uses. The frame type is also switched between frames, so the sync pulse is seen to move by one slot without any disturbance to the data.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int DIV_DEFAULT   = 18;
  localparam int FRAME_DEFAULT = 256;
  localparam int WORD_DEFAULT  = 16;

  // Single-cycle strobes marking where the bit clock is about to change.
  typedef struct packed {
    logic rise;
    logic fall;
  } bit_edge_t;
endpackage

// File: rtl/sport_bitclk_gen.sv
module sport_bitclk_gen
  import sport_pkg::*;
#(
  parameter int DIV = DIV_DEFAULT
) (
  input  logic      clk,
  input  logic      rst,
  output logic      sclk,
  output bit_edge_t strb
);
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt;

  assign strb.rise = (cnt == CW'(DIV - 1));
  assign strb.fall = (cnt == CW'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= strb.rise ? '0 : cnt + 1'b1;
      if (strb.rise)      sclk <= 1'b1;
      else if (strb.fall) sclk <= 1'b0;
    end
  end

  // Checker: count how long the bit clock stays high.
  logic [CW:0] hi_len;
  always_ff @(posedge clk) begin
    if (rst)       hi_len <= '0;
    else if (sclk) hi_len <= hi_len + 1'b1;
    else           hi_len <= '0;
  end

  // R1: each high phase lasts exactly half the division ratio
  p_sclk_high_len_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_len == (CW+1)'(HALF)));
endmodule

// File: rtl/sport_slot_ctr.sv
module sport_slot_ctr #(
  parameter int FRAME_BITS = 256,
  localparam int SW = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  output logic [SW-1:0] slot,
  output logic [SW-1:0] slot_nxt
);
  localparam logic [SW-1:0] LAST = SW'(FRAME_BITS - 1);

  assign slot_nxt = (slot == LAST) ? '0 : slot + 1'b1;

  always_ff @(posedge clk) begin
    if (rst)       slot <= LAST;
    else if (rise) slot <= slot_nxt;
  end
endmodule

// File: rtl/sport_tx_path.sv
module sport_tx_path #(
  parameter int WORD_BITS = 16,
  parameter int SW        = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rise,
  input  logic                 frame_late,
  input  logic [SW-1:0]        slot_nxt,
  input  logic [WORD_BITS-1:0] tx_word,
  output logic                 fsync,
  output logic                 sdo,
  output logic                 tx_load
);
  localparam logic [SW-1:0] LAST_DATA = SW'(WORD_BITS);

  logic [WORD_BITS-1:0] sh;
  logic                 data_slot;

  assign data_slot = (slot_nxt != '0) && (slot_nxt <= LAST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      sdo     <= 1'b0;
      fsync   <= 1'b0;
      tx_load <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (rise) begin
        fsync <= frame_late ? (slot_nxt == SW'(1)) : (slot_nxt == '0);
        if (slot_nxt == '0) begin
          sh      <= tx_word;
          tx_load <= 1'b1;
          sdo     <= 1'b0;
        end else if (data_slot) begin
          sdo <= sh[WORD_BITS-1];
          sh  <= {sh[WORD_BITS-2:0], 1'b0};
        end else begin
          sdo <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sport_rx_path.sv
module sport_rx_path #(
  parameter int WORD_BITS = 16,
  parameter int SW        = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fall,
  input  logic [SW-1:0]        slot,
  input  logic                 sdi,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_valid
);
  localparam logic [SW-1:0] LAST_DATA = SW'(WORD_BITS);

  logic [WORD_BITS-1:0] acc;
  logic                 in_data;

  assign in_data = (slot != '0) && (slot <= LAST_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rx_word  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (fall && in_data) begin
        acc <= {acc[WORD_BITS-2:0], sdi};
        if (slot == LAST_DATA) begin
          rx_word  <= {acc[WORD_BITS-2:0], sdi};
          rx_valid <= 1'b1;
        end
      end
    end
  end

  // R9: the valid strobe never lasts beyond one cycle
  p_rx_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

// File: rtl/sport_frame_master.sv
module sport_frame_master
  import sport_pkg::*;
#(
  parameter int DIV        = DIV_DEFAULT,
  parameter int FRAME_BITS = FRAME_DEFAULT,
  parameter int WORD_BITS  = WORD_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_late,
  input  logic [WORD_BITS-1:0] tx_word,
  input  logic                 sdi,
  output logic                 sclk,
  output logic                 fsync,
  output logic                 sdo,
  output logic                 tx_load,
  output logic [WORD_BITS-1:0] rx_word,
  output logic                 rx_valid
);
  localparam int SW = $clog2(FRAME_BITS);

  bit_edge_t     strb;
  logic [SW-1:0] slot;
  logic [SW-1:0] slot_nxt;

  sport_bitclk_gen #(.DIV(DIV)) u_bitclk (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .strb (strb)
  );

  sport_slot_ctr #(.FRAME_BITS(FRAME_BITS)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .rise     (strb.rise),
    .slot     (slot),
    .slot_nxt (slot_nxt)
  );

  sport_tx_path #(.WORD_BITS(WORD_BITS), .SW(SW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .rise       (strb.rise),
    .frame_late (frame_late),
    .slot_nxt   (slot_nxt),
    .tx_word    (tx_word),
    .fsync      (fsync),
    .sdo        (sdo),
    .tx_load    (tx_load)
  );

  sport_rx_path #(.WORD_BITS(WORD_BITS), .SW(SW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .fall     (strb.fall),
    .slot     (slot),
    .sdi      (sdi),
    .rx_word  (rx_word),
    .rx_valid (rx_valid)
  );

  // R2: slot index advances only together with a bit clock rising edge
  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot) |-> $rose(sclk));

  // R3: frame sync changes only at bit clock rising edges
  p_fsync_edge_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(fsync) |-> $rose(sclk));

  // R4: frame sync is confined to slot 0 or slot 1
  p_fsync_slot_r4: assert property (@(posedge clk) disable iff (rst)
    fsync |-> (slot == '0 || slot == SW'(1)));

  // R5: capture strobe coincides with the start of slot 0
  p_tx_load_slot_r5: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (slot == '0 && $rose(sclk)));

  // R6: serial output moves only with a rising bit clock
  p_sdo_edge_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdo) |-> $rose(sclk));

  // R7: output is low outside the data slots
  p_sdo_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (slot == '0 || slot > SW'(WORD_BITS)) |-> !sdo);

  // R9: received word is presented as the last data slot falls
  p_rx_valid_slot_r9: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (slot == SW'(WORD_BITS) && $fell(sclk)));
endmodule

// File: tb/sport_frame_master_tb.sv
module sport_frame_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 18;
  localparam int FRAME = 256;
  localparam int W     = 16;
  localparam int FRAME_CYC = DIV * FRAME;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_late = 1'b0;
  logic [W-1:0]  tx_word = 16'hA5C3;
  logic          sdi = 1'b0;
  logic          sclk, fsync, sdo, tx_load, rx_valid;
  logic [W-1:0]  rx_word;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sport_frame_master u_dut (
    .clk(clk), .rst(rst), .frame_late(frame_late), .tx_word(tx_word),
    .sdi(sdi), .sclk(sclk), .fsync(fsync), .sdo(sdo), .tx_load(tx_load),
    .rx_word(rx_word), .rx_valid(rx_valid)
  );

  task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Reference model state (behavioural, derived from edge counts)
  logic [W-1:0] m_lat = '0;
  logic [W-1:0] m_acc = '0;
  logic [W-1:0] m_rx  = '0;
  logic         m_fs  = 1'b0;

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int e;
    int slot;
    bit rise, fall, s_exp, sdo_exp, rv_exp, ld_exp;
    // R10: reset state
    repeat (4) begin
      @(negedge clk);
      chk("R10 sclk", {15'd0, sclk}, '0);
      chk("R10 fsync", {15'd0, fsync}, '0);
      chk("R10 sdo", {15'd0, sdo}, '0);
      chk("R10 tx_load", {15'd0, tx_load}, '0);
      chk("R10 rx_valid", {15'd0, rx_valid}, '0);
      chk("R10 rx_word", rx_word, '0);
    end
    rst = 1'b0;
    e = 0;
    while (e < 5 * FRAME_CYC + 2 * DIV) begin
      @(negedge clk);
      e++;
      rise  = (e >= DIV) && ((e - DIV) % DIV == 0);
      fall  = (e >= DIV + DIV/2) && ((e - DIV) % DIV == DIV/2);
      slot  = (e < DIV) ? FRAME - 1 : ((e - DIV) / DIV) % FRAME;
      s_exp = (e >= DIV) && ((e - DIV) % DIV < DIV/2);
      ld_exp = rise && slot == 0;
      if (ld_exp) m_lat = tx_word;
      if (rise) m_fs = frame_late ? (slot == 1) : (slot == 0);
      sdo_exp = (e >= DIV && slot >= 1 && slot <= W) ? m_lat[W - slot] : 1'b0;
      rv_exp = 1'b0;
      if (fall && slot >= 1 && slot <= W) begin
        m_acc = {m_acc[W-2:0], sdi};
        if (slot == W) begin
          m_rx   = m_acc;
          rv_exp = 1'b1;
        end
      end
      chk("R1 sclk", {15'd0, sclk}, {15'd0, s_exp});
      chk(frame_late ? "R4 fsync late" : "R3 fsync early", {15'd0, fsync}, {15'd0, m_fs});
      chk("R5 tx_load", {15'd0, tx_load}, {15'd0, ld_exp});
      chk((slot >= 1 && slot <= W) ? "R6 sdo data" : "R7 sdo idle", {15'd0, sdo}, {15'd0, sdo_exp});
      chk("R8 R9 rx_word", rx_word, m_rx);
      chk("R9 rx_valid", {15'd0, rx_valid}, {15'd0, rv_exp});
      // R2: the frame boundary repeats every 4608 system clocks
      if (ld_exp) chk("R2 frame period", 16'((e - DIV) % FRAME_CYC), '0);
      // stimulus updates after the comparison, held across the next edge
      sdi = 1'($urandom);
      if (e % 1013 == 77) tx_word = 16'($urandom);
      if (e == 2 * FRAME_CYC + 3 * DIV) frame_late = 1'b1;
      if (e == 4 * FRAME_CYC + 5 * DIV) frame_late = 1'b0;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule